// File: doc/BRIEF.md
# PCM Time-Slot Serial Port

This block is the digital side of a telephony voice codec's serial link. In every frame it sends one 8-bit companded sample on a serial output that can be tri-stated, and it collects one 8-bit sample from a serial input. The frame is paced by a bit clock and by a transmit and a receive frame-sync pulse, and all of these come from outside. The bit clock serves both directions. Every pin is brought into a faster system clock domain through a synchronizer chain. Edge strobes are then derived from the synchronized levels, and these strobes drive every shift and capture step.

The port finds the framing style on its own by measuring the width of the transmit sync pulse. A pulse that covers one or two falling bit-clock edges selects short framing. A pulse that covers three or more selects long framing, and each style has its own rules for when the output turns on and off and when receive bits are taken. The measured style applies from the following frame onward. Out of reset the port assumes short framing. The host loads the parallel transmit word before the slot starts. The received word is presented together with a one-cycle valid strobe, and an active-low slot indicator marks the eight transmit bit periods.

Top module: `pcm_slot_port`

## Requirements
- R1: While reset is held and right after it is released, the serial output enable is 0, the slot indicator is 1 (released) and the receive valid strobe is 0.
- R2: The port starts in short framing. When a transmit sync pulse ends, the port counts the falling bit-clock edges that saw the sync high. A count of 1 or 2 selects short framing and a count of 3 or more selects long framing. The new choice governs the following frames, not the frame that produced it.
- R3: In short framing, a falling bit-clock edge that sees transmit sync high arms the slot. The next rising edge turns the output on. The output turns off at the falling edge that follows the eighth rising edge of the slot.
- R4: In long framing, the output turns on at the later of two events: the rise of transmit sync, or a bit-clock high level after that rise.
- R5: In long framing, the output turns off at the later of two events: the falling bit-clock edge after the eighth bit period, or transmit sync going low.
- R6: The first transmitted bit is bit 7 of the transmit word. Each later rising bit-clock edge in the slot moves on to the next lower bit. The serial output changes at no other time while it is on.
- R7: The slot indicator is low from the moment the output turns on until the falling edge after the eighth bit period. A long sync pulse does not stretch it.
- R8: In short framing, a falling edge that sees receive sync high arms capture. The next eight falling edges take in the bits, and the first bit lands in bit 7 of the received word.
- R9: In long framing, a rise of receive sync arms capture. The next eight falling bit-clock edges take in the bits, first bit into bit 7.
- R10: After the eighth bit is captured, the received word is presented with a valid strobe that lasts exactly one system clock. The word then holds until the next strobe.
- R11: A sync pulse seen while a transmit or receive slot is in progress does not restart or extend that slot. For example, a two-period short pulse produces exactly one eight-bit slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples all pins |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_clk_i | input | 1 | Bit clock shared by both directions |
| tx_sync_i | input | 1 | Transmit frame sync, also used to classify the framing style |
| rx_sync_i | input | 1 | Receive frame sync |
| ser_in_i | input | 1 | Serial receive data |
| tx_word_i | input | 8 | Parallel word for the next transmit slot |
| ser_out_o | output | 1 | Serial transmit data, 0 while disabled |
| ser_out_en_o | output | 1 | Tri-state enable for the serial output |
| tx_slot_n_o | output | 1 | Active-low transmit slot indicator |
| rx_word_o | output | 8 | Last received word |
| rx_word_vld_o | output | 1 | One-cycle strobe when rx_word_o updates |

## Verification
The bench sweeps sync widths from one to eight bit periods. It starts each pulse either in the high or in the low half of the bit clock, so the order of the style changes from frame to frame varies too. One corner case is the style being applied to the frame that measured it instead of the next one; that would shift the first bit by one period. Another is a two-period short pulse being treated as a second arming, which would make a longer slot or a second receive strobe. The bench also covers a long pulse that outlasts the eighth bit, which must hold the output on while the slot indicator is already released. If the two were coupled, the indicator would be stretched or the output would be cut short. A sync that rises during the low half of the bit clock is included as well: a design that enabled the output on the sync edge alone would drive the sign bit half a period too early.

// File: rtl/pcm_port_pkg.sv
// Shared types and defaults for the PCM time-slot serial port.
package pcm_port_pkg;

    // Transmit slot sequencer states.
    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_ARMED = 2'd1,
        TX_SHIFT = 2'd2,
        TX_HOLD  = 2'd3
    } tx_state_e;

    // Receive slot sequencer states.
    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_CAPT = 1'b1
    } rx_state_e;

    localparam int unsigned DEF_WORD_BITS = 8;
    localparam int unsigned DEF_LONG_MIN  = 3;
    localparam int unsigned DEF_SYNC_DEPTH = 2;

endpackage

// File: rtl/pcm_pin_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous pins.
// Assumes: each bit is independent; STAGES >= 2. The output is the
// level seen at the last stage, delayed by STAGES system clocks.
module pcm_pin_sync #(
    parameter int unsigned N      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pins_i,
    output logic [N-1:0] lvl_o
);

    logic [STAGES-1:0][N-1:0] chain_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage: capture the raw pins.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= '0;
                    else        chain_q[0] <= pins_i;
                end
            end else begin : g_next
                // Later stages: pass the previous stage along.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= '0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign lvl_o = chain_q[STAGES-1];

endmodule

// File: rtl/pcm_edge_detect.sv
// Edge strobes for synchronized levels.
// Assumes: inputs are already in the clk domain. Each strobe lasts one cycle.
module pcm_edge_detect #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);

    logic [N-1:0] prev_q;

    // Remember the level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;
    assign fall_o = ~lvl_i & prev_q;

endmodule

// File: rtl/pcm_frame_classifier.sv
// Decides short or long framing from the width of the transmit sync pulse.
// Assumes: the width is counted in falling bit-clock edges that see the sync
// high. The decision is taken when the pulse ends and holds for later frames.
module pcm_frame_classifier #(
    parameter int unsigned WORD_BITS = 8,
    parameter int unsigned LONG_MIN  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_lvl_i,
    input  logic sync_rise_i,
    input  logic sync_fall_i,
    input  logic bclk_fall_i,
    output logic long_mode_o
);

    localparam int unsigned CNT_W = $clog2(WORD_BITS + 2);

    logic [CNT_W-1:0] width_q;
    logic             long_q;

    // Measure the pulse width and classify it when the pulse ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width_q <= '0;
            long_q  <= 1'b0;
        end else begin
            if (sync_rise_i) begin
                width_q <= '0;
            end else if (bclk_fall_i && sync_lvl_i && (width_q != '1)) begin
                width_q <= width_q + 1'b1;
            end
            if (sync_fall_i) begin
                long_q <= (width_q >= CNT_W'(LONG_MIN));
            end
        end
    end

    assign long_mode_o = long_q;

    // R2: the framing style only changes right after a sync pulse ends.
    p_style_moves_at_sync_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(long_q) |-> $past(sync_fall_i));

endmodule

// File: rtl/pcm_tx_slot.sv
// Transmit slot sequencer: loads the parallel word, shifts it out MSB first
// on rising bit-clock strobes and controls the tri-state enable and slot flag.
// Assumes: the framing style is latched when the slot is armed.
module pcm_tx_slot
    import pcm_port_pkg::*;
#(
    parameter int unsigned WORD_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 long_mode_i,
    input  logic                 sync_lvl_i,
    input  logic                 sync_rise_i,
    input  logic                 bclk_lvl_i,
    input  logic                 bclk_rise_i,
    input  logic                 bclk_fall_i,
    input  logic [WORD_BITS-1:0] word_i,
    output logic                 ser_o,
    output logic                 ser_en_o,
    output logic                 slot_n_o
);

    localparam int unsigned CNT_W = $clog2(WORD_BITS + 1);

    tx_state_e            state_q;
    logic                 frame_long_q;
    logic [WORD_BITS-1:0] shreg_q;
    logic [CNT_W-1:0]     sent_q;
    logic                 en_q;
    logic                 slot_q;

    // Sequence one transmit slot: arm, start, shift, and optionally hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= TX_IDLE;
            frame_long_q <= 1'b0;
            shreg_q      <= '0;
            sent_q       <= '0;
            en_q         <= 1'b0;
            slot_q       <= 1'b0;
        end else begin
            case (state_q)
                TX_IDLE: begin
                    if (long_mode_i && sync_rise_i) begin
                        state_q      <= TX_ARMED;
                        frame_long_q <= 1'b1;
                    end else if (!long_mode_i && bclk_fall_i && sync_lvl_i) begin
                        state_q      <= TX_ARMED;
                        frame_long_q <= 1'b0;
                    end
                end
                TX_ARMED: begin
                    if (frame_long_q && !sync_lvl_i) begin
                        state_q <= TX_IDLE;
                    end else if ((frame_long_q && bclk_lvl_i) ||
                                 (!frame_long_q && bclk_rise_i)) begin
                        shreg_q <= word_i;
                        sent_q  <= CNT_W'(1);
                        en_q    <= 1'b1;
                        slot_q  <= 1'b1;
                        state_q <= TX_SHIFT;
                    end
                end
                TX_SHIFT: begin
                    if (bclk_rise_i && (sent_q < CNT_W'(WORD_BITS))) begin
                        shreg_q <= {shreg_q[WORD_BITS-2:0], 1'b0};
                        sent_q  <= sent_q + 1'b1;
                    end else if (bclk_fall_i && (sent_q == CNT_W'(WORD_BITS))) begin
                        slot_q <= 1'b0;
                        if (frame_long_q && sync_lvl_i) begin
                            state_q <= TX_HOLD;
                        end else begin
                            en_q    <= 1'b0;
                            state_q <= TX_IDLE;
                        end
                    end
                end
                TX_HOLD: begin
                    if (!sync_lvl_i) begin
                        en_q    <= 1'b0;
                        state_q <= TX_IDLE;
                    end
                end
                default: state_q <= TX_IDLE;
            endcase
        end
    end

    assign ser_o    = en_q ? shreg_q[WORD_BITS-1] : 1'b0;
    assign ser_en_o = en_q;
    assign slot_n_o = ~slot_q;

    // R4: the output only turns on while the bit clock is seen high.
    p_enable_with_clock_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_q) |-> $past(bclk_lvl_i));

    // R6: while on, the data moves only on a rising bit-clock strobe.
    p_shift_only_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && $past(en_q) && !$past(bclk_rise_i)) |-> $stable(shreg_q));

    // R3: the output never turns off before all bits were sent.
    p_off_after_full_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_q) |-> ($past(sent_q) == CNT_W'(WORD_BITS)));

    // R7: the slot indicator is only active while the output is on.
    p_slot_inside_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_n_o |-> en_q);

    // R5: a held output turns off once the sync is low.
    p_hold_ends_on_sync_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_HOLD && !sync_lvl_i) |=> !en_q);

endmodule

// File: rtl/pcm_rx_slot.sv
// Receive slot sequencer: arms on the receive sync and shifts in one bit per
// falling bit-clock strobe, MSB first, then presents the word with a strobe.
// Assumes: sync and data levels come through equal-depth synchronizers.
module pcm_rx_slot
    import pcm_port_pkg::*;
#(
    parameter int unsigned WORD_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 long_mode_i,
    input  logic                 sync_lvl_i,
    input  logic                 bclk_fall_i,
    input  logic                 data_i,
    output logic [WORD_BITS-1:0] word_o,
    output logic                 vld_o
);

    localparam int unsigned CNT_W = $clog2(WORD_BITS);

    rx_state_e            state_q;
    logic                 sync_prev_q;
    logic                 sync_rise;
    logic [WORD_BITS-1:0] shreg_q;
    logic [WORD_BITS-1:0] word_q;
    logic [CNT_W-1:0]     got_q;
    logic                 vld_q;

    // Keep the previous receive sync level for rise detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_prev_q <= 1'b0;
        else        sync_prev_q <= sync_lvl_i;
    end

    assign sync_rise = sync_lvl_i & ~sync_prev_q;

    // Arm on the sync, then take eight bits on falling strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            shreg_q <= '0;
            word_q  <= '0;
            got_q   <= '0;
            vld_q   <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            case (state_q)
                RX_IDLE: begin
                    if ((long_mode_i && sync_rise) ||
                        (!long_mode_i && bclk_fall_i && sync_lvl_i)) begin
                        state_q <= RX_CAPT;
                        got_q   <= '0;
                    end
                end
                RX_CAPT: begin
                    if (bclk_fall_i) begin
                        shreg_q <= {shreg_q[WORD_BITS-2:0], data_i};
                        if (got_q == CNT_W'(WORD_BITS - 1)) begin
                            word_q  <= {shreg_q[WORD_BITS-2:0], data_i};
                            vld_q   <= 1'b1;
                            state_q <= RX_IDLE;
                        end else begin
                            got_q <= got_q + 1'b1;
                        end
                    end
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end

    assign word_o = word_q;
    assign vld_o  = vld_q;

    // R10: the valid strobe lasts exactly one cycle.
    p_valid_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |=> !vld_q);

    // R10: the presented word holds between strobes.
    p_word_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_q |-> $stable(word_q));

    // R8: a word completes only on a falling bit-clock strobe.
    p_valid_on_clock_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |-> $past(bclk_fall_i));

endmodule

// File: rtl/pcm_slot_port.sv
// PCM time-slot serial port top: synchronizes the pins, derives the edge
// strobes, classifies the framing style and runs both slot sequencers.
// Assumes: one shared bit clock, slower than a quarter of clk.
module pcm_slot_port
    import pcm_port_pkg::*;
#(
    parameter int unsigned WORD_BITS  = DEF_WORD_BITS,
    parameter int unsigned LONG_MIN   = DEF_LONG_MIN,
    parameter int unsigned SYNC_DEPTH = DEF_SYNC_DEPTH
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_clk_i,
    input  logic                 tx_sync_i,
    input  logic                 rx_sync_i,
    input  logic                 ser_in_i,
    input  logic [WORD_BITS-1:0] tx_word_i,
    output logic                 ser_out_o,
    output logic                 ser_out_en_o,
    output logic                 tx_slot_n_o,
    output logic [WORD_BITS-1:0] rx_word_o,
    output logic                 rx_word_vld_o
);

    localparam int unsigned PIN_N  = 4;
    localparam int unsigned IX_BCK = 0;
    localparam int unsigned IX_TXS = 1;
    localparam int unsigned IX_RXS = 2;
    localparam int unsigned IX_DAT = 3;
    localparam int unsigned EDGE_N = 2;

    logic [PIN_N-1:0]  pin_lvl;
    logic [EDGE_N-1:0] edge_rise;
    logic [EDGE_N-1:0] edge_fall;
    logic              long_mode;

    pcm_pin_sync #(
        .N      (PIN_N),
        .STAGES (SYNC_DEPTH)
    ) pin_sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i ({ser_in_i, rx_sync_i, tx_sync_i, bit_clk_i}),
        .lvl_o  (pin_lvl)
    );

    pcm_edge_detect #(
        .N (EDGE_N)
    ) edge_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  ({pin_lvl[IX_TXS], pin_lvl[IX_BCK]}),
        .rise_o (edge_rise),
        .fall_o (edge_fall)
    );

    pcm_frame_classifier #(
        .WORD_BITS (WORD_BITS),
        .LONG_MIN  (LONG_MIN)
    ) classify_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_lvl_i  (pin_lvl[IX_TXS]),
        .sync_rise_i (edge_rise[1]),
        .sync_fall_i (edge_fall[1]),
        .bclk_fall_i (edge_fall[0]),
        .long_mode_o (long_mode)
    );

    pcm_tx_slot #(
        .WORD_BITS (WORD_BITS)
    ) tx_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .long_mode_i (long_mode),
        .sync_lvl_i  (pin_lvl[IX_TXS]),
        .sync_rise_i (edge_rise[1]),
        .bclk_lvl_i  (pin_lvl[IX_BCK]),
        .bclk_rise_i (edge_rise[0]),
        .bclk_fall_i (edge_fall[0]),
        .word_i      (tx_word_i),
        .ser_o       (ser_out_o),
        .ser_en_o    (ser_out_en_o),
        .slot_n_o    (tx_slot_n_o)
    );

    pcm_rx_slot #(
        .WORD_BITS (WORD_BITS)
    ) rx_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .long_mode_i (long_mode),
        .sync_lvl_i  (pin_lvl[IX_RXS]),
        .bclk_fall_i (edge_fall[0]),
        .data_i      (pin_lvl[IX_DAT]),
        .word_o      (rx_word_o),
        .vld_o       (rx_word_vld_o)
    );

endmodule

// File: tb/pcm_slot_port_tb_top.sv
// Sweep bench: sync widths 1..8, two start phases, varied words.
module pcm_slot_port_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_clk = 1'b0;
    logic       tx_sync = 1'b0;
    logic       rx_sync = 1'b0;
    logic       ser_in = 1'b0;
    logic [7:0] tx_word = '0;
    logic       ser_out;
    logic       ser_out_en;
    logic       tx_slot_n;
    logic [7:0] rx_word;
    logic       rx_vld;

    int n_chk = 0;
    int n_bad = 0;
    int vld_cycles = 0;
    logic [7:0] last_word = '0;
    bit done = 1'b0;
    bit mode_exp = 1'b0;

    always #10 clk = ~clk;

    pcm_slot_port dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .bit_clk_i     (bit_clk),
        .tx_sync_i     (tx_sync),
        .rx_sync_i     (rx_sync),
        .ser_in_i      (ser_in),
        .tx_word_i     (tx_word),
        .ser_out_o     (ser_out),
        .ser_out_en_o  (ser_out_en),
        .tx_slot_n_o   (tx_slot_n),
        .rx_word_o     (rx_word),
        .rx_word_vld_o (rx_vld)
    );

    // Count valid cycles and keep the last presented word.
    always @(posedge clk) begin
        if (rx_vld) begin
            vld_cycles <= vld_cycles + 1;
            last_word  <= rx_word;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One frame of 12 bit periods, 16 system clocks each.
    // s is the sync start offset (1 = clock high half, 10 = low half), w its width.
    task automatic run_frame(input logic [7:0] tw, input logic [7:0] rw,
                             input int w, input int s);
        bit lm = mode_exp;
        int f = (lm ? 0 : 1) + (s == 10 ? 1 : 0);
        int l = f + 7;
        int vc0 = vld_cycles;
        int first_seen = -1;
        int en_seen = 0;
        int en_exp = 0;
        tx_word = tw;
        for (int c = 0; c < 192; c++) begin
            int p = c / 16;
            int k = c % 16;
            @(negedge clk);
            if (k == 7 || k == 15) begin
                bit fs_high = (c >= s) && (c < w * 16 + s);
                bit started = (p >= f);
                bit past_word = (p > l) || (p == l && k == 15);
                bit exp_en = started && !(past_word && (!lm || !fs_high));
                bit exp_slot = started && !past_word;
                string tag = !lm ? "R3" : (past_word ? "R5" : "R4");
                check(ser_out_en == exp_en, tag, "output enable", ser_out_en, exp_en);
                check(tx_slot_n == !exp_slot, "R7", "slot indicator", tx_slot_n, !exp_slot);
                if (ser_out_en && k == 7 && first_seen < 0) first_seen = p;
                if (ser_out_en) en_seen++;
                if (exp_en) en_exp++;
                if (k == 7 && p >= f && p <= l)
                    check(ser_out == tw[7 - (p - f)], "R6", "serial bit", ser_out, tw[7 - (p - f)]);
            end
            bit_clk = (k < 8);
            tx_sync = (c >= s) && (c < w * 16 + s);
            rx_sync = tx_sync;
            if (p >= f && p <= l) ser_in = rw[7 - (p - f)];
            else                  ser_in = rw[0] ^ p[0];
        end
        check(first_seen == f, "R2", "first enabled bit period", first_seen, f);
        check(en_seen == en_exp, "R11", "enabled sample count", en_seen, en_exp);
        check(vld_cycles - vc0 == 1, "R10", "valid strobe cycles", vld_cycles - vc0, 1);
        check(last_word == rw, lm ? "R9" : "R8", "received word", last_word, rw);
        mode_exp = (w >= 3);
    endtask

    initial begin
        int idx = 0;
        repeat (5) @(negedge clk);
        // R1: reset state while reset is held.
        check(ser_out_en == 1'b0, "R1", "enable in reset", ser_out_en, 0);
        check(tx_slot_n == 1'b1, "R1", "slot in reset", tx_slot_n, 1);
        check(rx_vld == 1'b0, "R1", "valid in reset", rx_vld, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(ser_out_en == 1'b0, "R1", "enable after reset", ser_out_en, 0);
        check(tx_slot_n == 1'b1, "R1", "slot after reset", tx_slot_n, 1);
        for (int rep = 0; rep < 3; rep++) begin
            for (int w = 1; w <= 8; w++) begin
                for (int si = 0; si < 2; si++) begin
                    logic [7:0] tw = 8'(idx * 73 + 8'h5A);
                    logic [7:0] rw = 8'(idx * 151) ^ 8'hC3;
                    run_frame(tw, rw, (rep == 1) ? 9 - w : w, si == 0 ? 1 : 10);
                    idx++;
                end
            end
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule